// File: doc/BRIEF.md
# Bit-Slice Adder/Logic Unit with Overflow Flags

This block is a purely combinational arithmetic/logic unit for a datapath word. It is built from identical one-bit slices. Each slice holds a full adder and a small result selector, and the carry runs from slice to slice starting at bit 0. A two-bit operation code picks the result for every slice: the bitwise AND, the bitwise OR, or the adder sum.

A separate subtract control sends every B bit through an exclusive-OR inverter. The same control also feeds the carry-in of the lowest slice. This turns the adder path into a two's-complement subtractor. The block reports the carry leaving the top slice and an unsigned overflow flag. It also reports a signed overflow flag, formed from the two carries around the top slice.

There is no state, so there are no states or transitions. The selector, the adder and the flag logic follow their inputs within the same cycle.

Top module: `bsa_alu`

## Requirements
- R1: With op = 0 the result is A AND B, bit by bit.
- R2: With op = 1 the result is A OR B, bit by bit.
- R3: With op = 2 and sub = 0 the result is the low WIDTH bits of A + B, and carry_out is bit WIDTH of that sum.
- R4: With op = 2 and sub = 1 the result is the low WIDTH bits of A − B, computed as A + ~B + 1. carry_out is 1 exactly when A ≥ B as unsigned numbers.
- R5: unsigned_ovf equals carry_out when sub = 0 (the sum does not fit) and the inverse of carry_out when sub = 1 (a borrow occurred). The bench checks it for op = 2.
- R6: signed_ovf is the exclusive-OR of the carry into the top slice and the carry out of it. It is 1 only when A and the effective B (B, or ~B when subtracting) share a sign bit and the result's sign bit differs from it.
- R7: op = 3 is reserved and gives an all-zero result.
- R8: With WIDTH = 4, 0111 + 0100 gives 1011 with carry_out 0 and signed_ovf 1, and 1100 + 1010 gives 0110 with carry_out 1 and signed_ovf 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| op | input | 2 | Result select: 0 AND, 1 OR, 2 adder, 3 reserved (zero) |
| sub | input | 1 | Invert B and set the lowest carry-in |
| result | output | WIDTH | Selected result word |
| carry_out | output | 1 | Carry leaving the top slice |
| unsigned_ovf | output | 1 | Unsigned overflow or borrow |
| signed_ovf | output | 1 | Two's-complement overflow |

## Verification
The bench builds the unit twice, with WIDTH = 4 and with WIDTH = 32.

The 4-bit build makes the sign bit and the full carry range reachable with small hand-worked vectors:
- the two same-sign overflow examples;
- a borrow;
- a negative-minus-positive overflow.

The 32-bit build is driven with random operands and every operation code, and its outputs are compared against a wide-integer model. Hand-picked corners cover the all-ones wrap, the largest positive plus one, and zero minus zero.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
    typedef enum logic [1:0] {
        SEL_AND = 2'd0,
        SEL_OR  = 2'd1,
        SEL_SUM = 2'd2,
        SEL_RSV = 2'd3
    } sel_e;
endpackage

// File: rtl/bsa_slice.sv
module bsa_slice
    import bsa_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       inv_i,
    input  logic       cin_i,
    input  logic [1:0] sel_i,
    output logic       res_o,
    output logic       cout_o
);
    logic bx;
    logic half;
    logic sum;
    sel_e sel;

    assign sel    = sel_e'(sel_i);
    assign bx     = b_i ^ inv_i;
    assign half   = a_i ^ bx;
    assign sum    = half ^ cin_i;
    assign cout_o = (a_i & bx) | (half & cin_i);

    always_comb begin
        unique case (sel)
            SEL_AND: res_o = a_i & b_i;
            SEL_OR:  res_o = a_i | b_i;
            SEL_SUM: res_o = sum;
            SEL_RSV: res_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bsa_flags.sv
module bsa_flags (
    input  logic c_into_top,
    input  logic c_out_top,
    input  logic sub_i,
    output logic uovf_o,
    output logic sovf_o
);
    assign uovf_o = c_out_top ^ sub_i;
    assign sovf_o = c_into_top ^ c_out_top;
endmodule

// File: rtl/bsa_alu.sv
module bsa_alu
    import bsa_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [1:0]       op,
    input  logic             sub,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             unsigned_ovf,
    output logic             signed_ovf
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH:0] chain;

    assign chain[0] = sub;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        bsa_slice u_slice (
            .a_i    (opa[i]),
            .b_i    (opb[i]),
            .inv_i  (sub),
            .cin_i  (chain[i]),
            .sel_i  (op),
            .res_o  (result[i]),
            .cout_o (chain[i+1])
        );
    end

    assign carry_out = chain[WIDTH];

    bsa_flags u_flags (
        .c_into_top (chain[TOP]),
        .c_out_top  (chain[WIDTH]),
        .sub_i      (sub),
        .uovf_o     (unsigned_ovf),
        .sovf_o     (signed_ovf)
    );

    // Independent wide-arithmetic model used by the checks below.
    logic [WIDTH-1:0] beff;
    logic [WIDTH:0]   wide;
    assign beff = sub ? ~opb : opb;
    assign wide = {1'b0, opa} + {1'b0, beff} + {{WIDTH{1'b0}}, sub};

    always_comb begin
        if (op == 2'd0) assert_and_R1: assert (result == (opa & opb));
        if (op == 2'd1) assert_or_R2: assert (result == (opa | opb));
        if (op == 2'd2) assert_sum_R3: assert ({carry_out, result} == wide);
        if (op == 2'd3) assert_rsv_zero_R7: assert (result == '0);
        assert_uovf_R5: assert (unsigned_ovf == (wide[WIDTH] ^ sub));
        if (signed_ovf)
            assert_sovf_sign_R6: assert ((opa[TOP] == beff[TOP]) && (wide[TOP] != opa[TOP]));
    end
endmodule

// File: tb/sim_bsa_alu.sv
module sim_bsa_alu;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [31:0] a32, b32, r32;
    logic [1:0]  op32;
    logic        s32, c32, u32, v32;
    logic [3:0]  a4, b4, r4;
    logic [1:0]  op4;
    logic        s4, c4, u4, v4;

    bsa_alu #(.WIDTH(32)) u0 (
        .opa(a32), .opb(b32), .op(op32), .sub(s32),
        .result(r32), .carry_out(c32), .unsigned_ovf(u32), .signed_ovf(v32));
    bsa_alu #(.WIDTH(4)) u1 (
        .opa(a4), .opb(b4), .op(op4), .sub(s4),
        .result(r4), .carry_out(c4), .unsigned_ovf(u4), .signed_ovf(v4));

    typedef struct {
        bit          narrow;
        bit          flags;
        string       req;
        logic [31:0] res;
        logic        c, u, v;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected item per cycle.
    always @(posedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            if (it.narrow) begin
                check(it.req, {28'd0, r4}, it.res);
                if (it.flags) begin
                    check({it.req, " carry"}, {31'd0, c4}, {31'd0, it.c});
                    check("R5 unsigned_ovf", {31'd0, u4}, {31'd0, it.u});
                    check("R6 signed_ovf", {31'd0, v4}, {31'd0, it.v});
                end
            end else begin
                check(it.req, r32, it.res);
                if (it.flags) begin
                    check({it.req, " carry"}, {31'd0, c32}, {31'd0, it.c});
                    check("R5 unsigned_ovf", {31'd0, u32}, {31'd0, it.u});
                    check("R6 signed_ovf", {31'd0, v32}, {31'd0, it.v});
                end
            end
        end
    end

    task automatic drive4(input string req, input logic [3:0] a, input logic [3:0] b,
                          input logic s, input logic [3:0] er, input logic ec,
                          input logic eu, input logic ev);
        item_t it;
        @(negedge clk);
        a4 = a; b4 = b; op4 = 2'd2; s4 = s;
        it.narrow = 1'b1; it.flags = 1'b1; it.req = req;
        it.res = {28'd0, er}; it.c = ec; it.u = eu; it.v = ev;
        q.push_back(it);
    endtask

    task automatic drive32(input logic [31:0] a, input logic [31:0] b,
                           input logic [1:0] o, input logic s);
        item_t it;
        logic [31:0] bx;
        logic [32:0] w;
        @(negedge clk);
        a32 = a; b32 = b; op32 = o; s32 = s;
        bx = s ? ~b : b;
        w = {1'b0, a} + {1'b0, bx} + {32'd0, s};
        it.narrow = 1'b0; it.flags = 1'b0;
        it.c = w[32]; it.u = w[32] ^ s;
        it.v = (a[31] == bx[31]) && (w[31] != a[31]);
        case (o)
            2'd0: begin it.req = "R1 and"; it.res = a & b; end
            2'd1: begin it.req = "R2 or";  it.res = a | b; end
            2'd2: begin
                it.req = s ? "R4 sub" : "R3 add";
                it.res = s ? a - b : a + b;
                it.flags = 1'b1;
            end
            default: begin it.req = "R7 reserved"; it.res = 32'd0; end
        endcase
        q.push_back(it);
    endtask

    initial begin
        a32 = '0; b32 = '0; op32 = '0; s32 = 1'b0;
        a4 = '0; b4 = '0; op4 = '0; s4 = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset-state result", r32, 32'd0);
        rst_n = 1'b1;
        // R8 worked examples on the narrow build
        drive4("R8 7+4", 4'b0111, 4'b0100, 1'b0, 4'b1011, 1'b0, 1'b0, 1'b1);
        drive4("R8 -4+-6", 4'b1100, 4'b1010, 1'b0, 4'b0110, 1'b1, 1'b1, 1'b1);
        drive4("R4 3-5 borrow", 4'b0011, 4'b0101, 1'b1, 4'b1110, 1'b0, 1'b1, 1'b0);
        drive4("R4 -8-1", 4'b1000, 4'b0001, 1'b1, 4'b0111, 1'b1, 1'b0, 1'b1);
        drive4("R4 5-5", 4'b0101, 4'b0101, 1'b1, 4'b0000, 1'b1, 1'b0, 1'b0);
        // 32-bit corners
        drive32(32'hFFFF_FFFF, 32'd1, 2'd2, 1'b0);
        drive32(32'h7FFF_FFFF, 32'd1, 2'd2, 1'b0);
        drive32(32'd0, 32'd0, 2'd2, 1'b1);
        drive32(32'h8000_0000, 32'd1, 2'd2, 1'b1);
        drive32(32'hF0F0_1234, 32'h0FF0_FFFF, 2'd0, 1'b0);
        drive32(32'hF0F0_1234, 32'h0FF0_0000, 2'd1, 1'b1);
        drive32(32'hDEAD_BEEF, 32'hFFFF_FFFF, 2'd3, 1'b0);
        for (int k = 0; k < 400; k++)
            drive32($urandom, $urandom, 2'($urandom), 1'($urandom));
        while (q.size() > 0) @(posedge clk);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #50000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule